// File: doc/BRIEF.md
# Four-Slot Descriptor Submission Ring

This block queues transfer descriptors between software and a transfer engine. Software assembles each descriptor by writing four 32-bit words in a row to a single word port: address bits 31:0, address bits 63:32, byte length, then flags. The fourth word commits the assembled entry into one of four slots. On the other side, a valid/ready pop interface presents the oldest committed descriptor, and the engine takes it with a handshake.

A read-only status word shows both slot pointers and the full, empty and error flags. Software uses the status word to decide how many more descriptors fit and to spot a dropped submission. A control bit holds the ring in reset. The error flag is cleared by writing one to it.

Top module: `desc_ring`

## Requirements
- R1: After rst_n is released the status word reads 0x100, meaning empty is set, both slot pointers are 0 and error is clear. pop_valid is low.
- R2: The write slot advances by one only when the fourth word of a descriptor is accepted. The first three words leave the status word unchanged.
- R3: A popped descriptor presents pop_addr = {second word, first word}, pop_len = third word and pop_flags = fourth word. pop_notify equals bit 16 of the flags word.
- R4: The status word layout is: bits 1:0 write slot, bits 5:4 read slot, bit 8 empty, bit 9 full, bit 10 error. All other bits read 0.
- R5: With four descriptors held, full is 1, empty is 0 and the two slot pointers are equal. Full and empty are never both set.
- R6: pop_valid is high exactly when the ring holds a descriptor and is not held in reset. Each cycle with pop_valid and pop_ready high advances the read slot by one. Descriptors leave in commit order.
- R7: If a fourth word arrives while the ring is full and no pop happens in that cycle, the descriptor is dropped and error is set. The word counter returns to zero, so the next four words form a new descriptor.
- R8: If a fourth word arrives in the same cycle as a pop from a full ring, the descriptor is accepted. Error stays clear and the ring stays full, with both pointers advanced.
- R9: A status write with stat_err_w1 = 1 clears error. A status write with stat_err_w1 = 0 leaves error unchanged.
- R10: A control write with ctl_rst = 1 holds the ring in reset. One cycle later the ring is empty, both pointers are 0 and any partial word count is discarded. Word writes are ignored while the reset is held. A control write with ctl_rst = 0 releases the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Descriptor word write strobe |
| wr_data | input | 32 | Descriptor word |
| ctl_we | input | 1 | Control register write strobe |
| ctl_rst | input | 1 | Value written to the ring-reset bit |
| stat_we | input | 1 | Status register write strobe |
| stat_err_w1 | input | 1 | Value written at status bit 10 (1 clears error) |
| status | output | 32 | Slot pointers and full/empty/error flags |
| pop_valid | output | 1 | Oldest descriptor available |
| pop_ready | input | 1 | Consumer takes the descriptor |
| pop_addr | output | 64 | Descriptor address |
| pop_len | output | 32 | Descriptor length |
| pop_flags | output | 32 | Descriptor flags word |
| pop_notify | output | 1 | Completion notification requested |

## Verification
The fourth word of a submission can land in the same cycle as a pop by the engine, and on a full ring this cycle decides between acceptance and an overflow error. The bench fills the ring, writes three words of a fifth descriptor, and then drives the last word together with pop_ready. The result is judged from the status word, which must keep error clear, stay full and show both pointers advanced. The pops that follow must show the new descriptor arriving after the three older ones. A separate case drives the same last word without a pop and expects the drop and the error.

// File: rtl/desc_ring.sv
module desc_ring #(
  parameter int WORD_W     = 32,
  parameter int NOTIFY_BIT = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [WORD_W-1:0]   wr_data,
  input  logic                ctl_we,
  input  logic                ctl_rst,
  input  logic                stat_we,
  input  logic                stat_err_w1,
  output logic [31:0]         status,
  output logic                pop_valid,
  input  logic                pop_ready,
  output logic [2*WORD_W-1:0] pop_addr,
  output logic [WORD_W-1:0]   pop_len,
  output logic [WORD_W-1:0]   pop_flags,
  output logic                pop_notify
);
  localparam int SLOTS = 4;
  localparam int PW    = 2;
  localparam int CW    = 3;
  localparam int EW    = 4 * WORD_W;

  logic [PW-1:0]     wptr, rptr;
  logic [CW-1:0]     cnt;
  logic [1:0]        wcnt;
  logic              err, ring_rst;
  logic [WORD_W-1:0] stage [4];
  logic [EW-1:0]     slot_q [SLOTS];
  logic [EW-1:0]     head;

  logic full, empty, last_word, pop, push, ovf;

  assign full      = (cnt == CW'(SLOTS));
  assign empty     = (cnt == '0);
  assign pop_valid = !empty && !ring_rst;
  assign pop       = pop_valid && pop_ready;
  assign last_word = wr_en && !ring_rst && (wcnt == 2'd3);
  assign push      = last_word && (!full || pop);
  assign ovf       = last_word && full && !pop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ring_rst <= 1'b0;
    else if (ctl_we) ring_rst <= ctl_rst;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
      wcnt <= '0;
    end else if (ring_rst) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
      wcnt <= '0;
    end else begin
      if (wr_en) wcnt <= wcnt + 2'd1;
      if (push)  wptr <= wptr + PW'(1);
      if (pop)   rptr <= rptr + PW'(1);
      case ({push, pop})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        err <= 1'b0;
    else if (ovf)                      err <= 1'b1;
    else if (stat_we && stat_err_w1)   err <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (wr_en && !ring_rst && wcnt != 2'd3) stage[wcnt] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (push) slot_q[wptr] <= {wr_data, stage[2], stage[1], stage[0]};
  end

  assign head       = slot_q[rptr];
  assign pop_addr   = head[2*WORD_W-1:0];
  assign pop_len    = head[3*WORD_W-1:2*WORD_W];
  assign pop_flags  = head[4*WORD_W-1:3*WORD_W];
  assign pop_notify = pop_flags[NOTIFY_BIT];

  assign status = {21'b0, err, full, empty, 2'b0, rptr, 2'b0, wptr};
endmodule

module desc_ring_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        ring_rst,
  input logic [1:0]  wcnt,
  input logic [31:0] status,
  input logic        pop_valid,
  input logic        pop_ready
);
  p_full_empty_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(status[9] && status[8]));

  p_no_valid_when_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    status[8] |-> !pop_valid);

  p_pop_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_valid && pop_ready) |=> (status[5:4] == $past(status[5:4]) + 2'd1));

  p_wslot_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr_en && wcnt == 2'd3) && !ring_rst) |=> $stable(status[1:0]));

  p_overflow_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !ring_rst && wcnt == 2'd3 && status[9] && !(pop_valid && pop_ready))
      |=> status[10]);

  p_ring_reset_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ring_rst |=> (status[8] && status[5:4] == 2'd0 && status[1:0] == 2'd0));
endmodule

bind desc_ring desc_ring_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .ring_rst(ring_rst), .wcnt(wcnt),
  .status(status), .pop_valid(pop_valid), .pop_ready(pop_ready)
);

// File: tb/desc_ring_bench.sv
module desc_ring_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        ctl_we = 1'b0, ctl_rst = 1'b0;
  logic        stat_we = 1'b0, stat_err_w1 = 1'b0;
  logic [31:0] status;
  logic        pop_valid;
  logic        pop_ready = 1'b0;
  logic [63:0] pop_addr;
  logic [31:0] pop_len, pop_flags;
  logic        pop_notify;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  desc_ring u_desc_ring (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .ctl_we(ctl_we), .ctl_rst(ctl_rst), .stat_we(stat_we), .stat_err_w1(stat_err_w1),
    .status(status), .pop_valid(pop_valid), .pop_ready(pop_ready),
    .pop_addr(pop_addr), .pop_len(pop_len), .pop_flags(pop_flags), .pop_notify(pop_notify)
  );

  function automatic logic [31:0] stw(bit e, bit f, bit m, int r, int w);
    return {21'b0, e, f, m, 2'b0, 2'(r), 2'b0, 2'(w)};
  endfunction

  function automatic logic [31:0] w_lo(int id);  return 32'h0001_0000 * id + 32'h100; endfunction
  function automatic logic [31:0] w_hi(int id);  return 32'h8000_0000 | id;           endfunction
  function automatic logic [31:0] w_len(int id); return 32'h40 * (id + 1);            endfunction
  function automatic logic [31:0] w_flg(int id, bit n);
    return (n ? 32'h0001_0000 : 32'h0) | 32'(id);
  endfunction

  task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic put_word(logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic put_desc(int id, bit n);
    put_word(w_lo(id)); put_word(w_hi(id)); put_word(w_len(id)); put_word(w_flg(id, n));
  endtask

  task automatic take(int id, bit n, string req);
    @(negedge clk);
    chk({req, " valid"}, 64'(pop_valid), 64'(1));
    chk({req, " addr"},  pop_addr, {w_hi(id), w_lo(id)});
    chk({req, " len"},   64'(pop_len), 64'(w_len(id)));
    chk({req, " flags"}, 64'(pop_flags), 64'(w_flg(id, n)));
    chk({req, " notify"}, 64'(pop_notify), 64'(n));
    pop_ready = 1'b1;
    @(negedge clk); pop_ready = 1'b0;
  endtask

  task automatic stat_write(bit v);
    @(negedge clk); stat_we = 1'b1; stat_err_w1 = v;
    @(negedge clk); stat_we = 1'b0; stat_err_w1 = 1'b0;
  endtask

  task automatic ctl_write(bit v);
    @(negedge clk); ctl_we = 1'b1; ctl_rst = v;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic t_reset_state;
    chk("R1 R4 status after reset", 64'(status), 64'(stw(0, 0, 1, 0, 0)));
    chk("R1 pop_valid after reset", 64'(pop_valid), 64'(0));
  endtask

  task automatic t_single_commit;
    put_word(w_lo(1)); put_word(w_hi(1)); put_word(w_len(1));
    chk("R2 status after three words", 64'(status), 64'(stw(0, 0, 1, 0, 0)));
    put_word(w_flg(1, 1));
    chk("R2 R4 status after commit", 64'(status), 64'(stw(0, 0, 0, 0, 1)));
    take(1, 1, "R3 R6 first descriptor");
    chk("R6 status after pop", 64'(status), 64'(stw(0, 0, 1, 1, 1)));
  endtask

  task automatic t_fill;
    put_desc(2, 0); put_desc(3, 1); put_desc(4, 0); put_desc(5, 1);
    chk("R5 status when full", 64'(status), 64'(stw(0, 1, 0, 1, 1)));
  endtask

  task automatic t_overflow_and_clear;
    put_desc(99, 1);
    chk("R7 overflow sets error", 64'(status), 64'(stw(1, 1, 0, 1, 1)));
    stat_write(1'b0);
    chk("R9 write zero keeps error", 64'(status), 64'(stw(1, 1, 0, 1, 1)));
    stat_write(1'b1);
    chk("R9 write one clears error", 64'(status), 64'(stw(0, 1, 0, 1, 1)));
    take(2, 0, "R6 R7 oldest after overflow");
    chk("R6 status after pop", 64'(status), 64'(stw(0, 0, 0, 2, 1)));
    put_desc(6, 0);
    chk("R7 fresh descriptor accepted", 64'(status), 64'(stw(0, 1, 0, 2, 2)));
  endtask

  task automatic t_push_pop_same_cycle;
    put_word(w_lo(7)); put_word(w_hi(7)); put_word(w_len(7));
    @(negedge clk);
    chk("R8 head before concurrent pop", pop_addr, {w_hi(3), w_lo(3)});
    wr_en = 1'b1; wr_data = w_flg(7, 1); pop_ready = 1'b1;
    @(negedge clk); wr_en = 1'b0; pop_ready = 1'b0;
    chk("R8 concurrent push and pop", 64'(status), 64'(stw(0, 1, 0, 3, 3)));
    take(4, 0, "R6 order 4");
    take(5, 1, "R6 order 5");
    take(6, 0, "R7 order 6");
    take(7, 1, "R8 order 7");
    chk("R6 drained status", 64'(status), 64'(stw(0, 0, 1, 3, 3)));
  endtask

  task automatic t_ring_reset;
    put_desc(8, 0);
    chk("R6 one held", 64'(status), 64'(stw(0, 0, 0, 3, 0)));
    put_word(w_lo(50)); put_word(w_hi(50));
    ctl_write(1'b1);
    @(negedge clk);
    chk("R10 reset empties ring", 64'(status), 64'(stw(0, 0, 1, 0, 0)));
    chk("R10 no valid in reset", 64'(pop_valid), 64'(0));
    put_desc(51, 1);
    chk("R10 writes ignored in reset", 64'(status), 64'(stw(0, 0, 1, 0, 0)));
    ctl_write(1'b0);
    put_desc(9, 1);
    chk("R10 ring works after release", 64'(status), 64'(stw(0, 0, 0, 0, 1)));
    take(9, 1, "R10 partial words discarded");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_single_commit();
    t_fill();
    t_overflow_and_clear();
    t_push_pop_same_cycle();
    t_ring_reset();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule